// File: doc/BRIEF.md
# Successive-Approximation Converter Controller

This block sequences a 10-bit successive-approximation conversion for an external analog front end. The multiplexer, trial DAC and comparator sit outside the block. The controller drives a channel select and a trial code out to them, and reads back a single comparator bit. Software starts a conversion by writing a command byte that names one of 16 channels. It then either polls a ready flag or waits for a single-cycle completion interrupt. After that it reads the 16-bit result as two bytes.

Every conversion takes the same fixed number of clock cycles, counted from the command write, and that count is a parameter. The cycles are spent first in a short sample phase. Then come ten equal bit-decision steps, from the most significant bit down. The result word carries the converted channel number in its low nibble, so the software that reads it can tell which input the value belongs to. The 10-bit value sits left-justified in the upper bits. Only one conversion runs at a time. A new command written during a conversion abandons the old one and starts over.

Top module: `sar_conv_ctrl`

## Requirements
- R1: A write to address 0 starts a conversion on the channel given by data bits 3:0, and `chanSel` shows that channel from the next cycle. Data bits 7:4 have no effect.
- R2: The ready flag (bit 0 read at address 3) is low from the cycle after a command write. It rises exactly TOTAL_STATES (default 174) clock edges after the edge that captured the write.
- R3: The low byte of the result is read at address 1 as {value[1:0], 2'b00, channel[3:0]}. The high byte is read at address 2 as value[9:2]. Bits 5:4 of the low byte always read 0.
- R4: After the command, `dacCode` is 0 for TOTAL_STATES - 10*STEP_STATES cycles (the sample phase). Then ten steps of STEP_STATES cycles (default 17) follow, starting from the MSB. Each step sets its trial bit when it begins, and keeps that bit only if `cmpIn` is 1 on the step's last cycle. For an input code from 0 to 1023 the result equals that code.
- R5: An input above full scale, where `cmpIn` is 1 against every trial code, converts to 1023.
- R6: Bit 1 at address 3 is a writable interrupt enable (reset 0). When it is set, `irqReq` is high for exactly one cycle, the first cycle in which ready is high. When it is clear, `irqReq` stays low.
- R7: A command written while a conversion is running abandons it and restarts on the new channel. Ready stays low until TOTAL_STATES edges after the new write, and the result holds the new channel.
- R8: Reads never clear ready, and only a command write does. Writes to addresses 1 and 2 are ignored. The result and `dacCode` hold their values until the next conversion.
- R9: After reset, ready, the interrupt enable, `irqReq`, `dacCode` and both result bytes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address: 0 command, 1 result low, 2 result high, 3 status/control |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for regAddr (combinational) |
| cmpIn | input | 1 | Comparator: 1 when the input is at or above the trial code |
| dacCode | output | 10 | Trial code to the external DAC |
| chanSel | output | 4 | Channel select to the external multiplexer |
| irqReq | output | 1 | One-cycle completion interrupt request |

## Verification
The bench times each conversion to the exact edge: ready must still be low one cycle before the count ends and high on it. A counter that is off by one, or a sample phase of the wrong length, shows up there, and so does a first trial code that appears early. Conversions at zero, full scale, alternating bit patterns and above full scale catch a search that keeps the wrong bit, drops the last decision or wraps on overflow. A restart in mid-conversion exposes a design that finishes on the old timeline or reports the old channel. Repeated reads and stray writes to the result addresses catch a ready flag that is cleared by a read, or a result that can be overwritten. The interrupt is watched both for a stuck or two-cycle pulse and for firing while it is disabled.

// File: rtl/sar_conv_pkg.sv
package sar_conv_pkg;
  localparam int RES_BITS = 10;
  localparam int CHAN_W   = 4;
  localparam int IDX_W    = $clog2(RES_BITS);
  localparam int WORD_W   = 16;

  typedef struct packed {
    logic             start;
    logic             firstTrial;
    logic             decide;
    logic             lastBit;
    logic [IDX_W-1:0] bitIdx;
  } sarStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SAMPLE,
    ST_STEP
  } sarState_t;
endpackage

// File: rtl/sar_conv_fsm.sv
module sar_conv_fsm
  import sar_conv_pkg::*;
#(
  parameter int TOTAL_STATES = 174,
  parameter int STEP_STATES  = 17
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdWr,
  input  logic       irqEn,
  output sarStrobe_t strobe,
  output logic       ready,
  output logic       irqPulse
);
  localparam int SAMPLE_STATES = TOTAL_STATES - RES_BITS * STEP_STATES;
  localparam int CNT_W = $clog2(TOTAL_STATES + 1);

  sarState_t        state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] bitIdx;

  always_comb begin
    strobe.start      = cmdWr;
    strobe.firstTrial = !cmdWr && (state == ST_SAMPLE) && (cnt == '0);
    strobe.decide     = !cmdWr && (state == ST_STEP) && (cnt == '0);
    strobe.lastBit    = (bitIdx == '0);
    strobe.bitIdx     = bitIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      bitIdx   <= '0;
      ready    <= 1'b0;
      irqPulse <= 1'b0;
    end else begin
      irqPulse <= 1'b0;
      if (cmdWr) begin
        state <= ST_SAMPLE;
        cnt   <= CNT_W'(SAMPLE_STATES - 1);
        ready <= 1'b0;
      end else begin
        case (state)
          ST_SAMPLE: begin
            if (cnt == '0) begin
              state  <= ST_STEP;
              cnt    <= CNT_W'(STEP_STATES - 1);
              bitIdx <= IDX_W'(RES_BITS - 1);
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
          ST_STEP: begin
            if (cnt == '0) begin
              if (bitIdx == '0) begin
                state    <= ST_IDLE;
                ready    <= 1'b1;
                irqPulse <= irqEn;
              end else begin
                bitIdx <= bitIdx - 1'b1;
                cnt    <= CNT_W'(STEP_STATES - 1);
              end
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sar_conv_datapath.sv
module sar_conv_datapath
  import sar_conv_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  sarStrobe_t          strobe,
  input  logic [CHAN_W-1:0]   cmdChan,
  input  logic                cmpIn,
  output logic [RES_BITS-1:0] dacCode,
  output logic [CHAN_W-1:0]   chanSel,
  output logic [WORD_W-1:0]   resultWord
);
  localparam int PAD_W = WORD_W - RES_BITS - CHAN_W;

  logic [RES_BITS-1:0] resultVal;
  logic [CHAN_W-1:0]   resultChan;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dacCode    <= '0;
      chanSel    <= '0;
      resultVal  <= '0;
      resultChan <= '0;
    end else begin
      if (strobe.start) begin
        dacCode <= '0;
        chanSel <= cmdChan;
      end
      if (strobe.firstTrial) begin
        dacCode[RES_BITS-1] <= 1'b1;
      end
      if (strobe.decide) begin
        dacCode[strobe.bitIdx] <= cmpIn;
        if (strobe.lastBit) begin
          resultVal  <= {dacCode[RES_BITS-1:1], cmpIn};
          resultChan <= chanSel;
        end else begin
          dacCode[strobe.bitIdx - 1'b1] <= 1'b1;
        end
      end
    end
  end

  assign resultWord = {resultVal, {PAD_W{1'b0}}, resultChan};
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_conv_pkg::*;
#(
  parameter int TOTAL_STATES = 174,
  parameter int STEP_STATES  = 17
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWr,
  input  logic [1:0]          regAddr,
  input  logic [7:0]          regWrData,
  output logic [7:0]          regRdData,
  input  logic                cmpIn,
  output logic [RES_BITS-1:0] dacCode,
  output logic [CHAN_W-1:0]   chanSel,
  output logic                irqReq
);
  localparam logic [1:0] ADDR_CMD  = 2'd0;
  localparam logic [1:0] ADDR_LOW  = 2'd1;
  localparam logic [1:0] ADDR_HIGH = 2'd2;
  localparam logic [1:0] ADDR_CTL  = 2'd3;

  sarStrobe_t        strobe;
  logic              ready;
  logic              irqEn;
  logic              cmdWr;
  logic [WORD_W-1:0] resultWord;

  assign cmdWr = regWr && (regAddr == ADDR_CMD);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             irqEn <= 1'b0;
    else if (regWr && regAddr == ADDR_CTL) irqEn <= regWrData[1];
  end

  sar_conv_fsm #(
    .TOTAL_STATES(TOTAL_STATES),
    .STEP_STATES (STEP_STATES)
  ) fsm_i (
    .clk     (clk),
    .rstN    (rstN),
    .cmdWr   (cmdWr),
    .irqEn   (irqEn),
    .strobe  (strobe),
    .ready   (ready),
    .irqPulse(irqReq)
  );

  sar_conv_datapath dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cmdChan   (regWrData[CHAN_W-1:0]),
    .cmpIn     (cmpIn),
    .dacCode   (dacCode),
    .chanSel   (chanSel),
    .resultWord(resultWord)
  );

  always_comb begin
    case (regAddr)
      ADDR_LOW:  regRdData = resultWord[7:0];
      ADDR_HIGH: regRdData = resultWord[15:8];
      ADDR_CTL:  regRdData = {6'b0, irqEn, ready};
      default:   regRdData = 8'h00;
    endcase
  end
endmodule

// File: rtl/sar_conv_checker.sv
module sar_conv_checker #(
  parameter int TOTAL_STATES = 174
) (
  input logic       clk,
  input logic       rstN,
  input logic       regWr,
  input logic [1:0] regAddr,
  input logic [7:0] regRdData,
  input logic [9:0] dacCode,
  input logic       irqReq,
  input logic       ready,
  input logic       irqEn
);
  logic        cmdSeen;
  logic        armed;
  logic [15:0] elapsed;

  assign cmdSeen = regWr && (regAddr == 2'd0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed   <= 1'b0;
      elapsed <= '0;
    end else if (cmdSeen) begin
      armed   <= 1'b1;
      elapsed <= '0;
    end else if (armed && !ready && elapsed != 16'hFFFF) begin
      elapsed <= elapsed + 1'b1;
    end
  end

  a_r2_low_after_cmd: assert property (@(posedge clk) disable iff (!rstN)
    cmdSeen |=> !ready);

  a_r2_latency: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> (armed && elapsed == 16'(TOTAL_STATES)));

  a_r6_irq_single: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |=> !irqReq);

  a_r6_irq_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> ($rose(ready) && $past(irqEn)));

  a_r3_zero_bits: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 2'd1) |-> (regRdData[5:4] == 2'b00));

  a_r8_code_hold: assert property (@(posedge clk) disable iff (!rstN)
    (ready && !cmdSeen) |=> $stable(dacCode));
endmodule

bind sar_conv_ctrl sar_conv_checker #(.TOTAL_STATES(TOTAL_STATES)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .regWr    (regWr),
  .regAddr  (regAddr),
  .regRdData(regRdData),
  .dacCode  (dacCode),
  .irqReq   (irqReq),
  .ready    (ready),
  .irqEn    (irqEn)
);

// File: tb/sar_conv_ctrl_tb_top.sv
module sar_conv_ctrl_tb_top;
  localparam int TOTAL  = 174;
  localparam int STEP   = 17;
  localparam int SAMPLE = TOTAL - 10 * STEP;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWr = 1'b0;
  logic [1:0] regAddr = 2'd3;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       cmpIn;
  logic [9:0] dacCode;
  logic [3:0] chanSel;
  logic       irqReq;

  int analogVal = 0;
  int checks = 0;
  int errors = 0;

  assign cmpIn = (analogVal >= int'(dacCode));

  always #10 clk = ~clk;

  sar_conv_ctrl dut_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .cmpIn(cmpIn),
    .dacCode(dacCode), .chanSel(chanSel), .irqReq(irqReq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWr = 1'b0; regAddr = 2'd3;
  endtask

  task automatic regRead(input logic [1:0] a, output int v);
    regAddr = a;
    #1;
    v = int'(regRdData);
  endtask

  task automatic checkResult(input int chan, input int val, input string req);
    int expV;
    int v;
    expV = (val > 1023) ? 1023 : val;
    regRead(2'd1, v);
    check({req, " R3 low byte"}, v, ((expV & 3) << 6) | chan);
    regRead(2'd2, v);
    check({req, " R3 high byte"}, v, expV >> 2);
  endtask

  // Waits out one conversion after the capturing edge, checking timing (R2, R4, R6).
  task automatic timeConv(input bit irqOn, input string req);
    int v;
    for (int k = 1; k <= TOTAL + 1; k++) begin
      @(negedge clk);
      if (k == SAMPLE - 1) check({req, " R4 dac zero in sample"}, int'(dacCode), 0);
      if (k == SAMPLE)     check({req, " R4 msb trial"}, int'(dacCode), 512);
      if (k == TOTAL - 1) begin
        regRead(2'd3, v);
        check({req, " R2 ready still low"}, v & 1, 0);
        check({req, " R6 irq before done"}, int'(irqReq), 0);
      end
      if (k == TOTAL) begin
        regRead(2'd3, v);
        check({req, " R2 ready set"}, v & 1, 1);
        check({req, " R6 irq at ready rise"}, int'(irqReq), irqOn ? 1 : 0);
      end
      if (k == TOTAL + 1) check({req, " R6 irq one cycle"}, int'(irqReq), 0);
    end
  endtask

  task automatic runConv(input int chan, input int val, input bit irqOn);
    regWrite(2'd3, irqOn ? 8'h02 : 8'h00);
    analogVal = val;
    regWrite(2'd0, 8'hA0 | 8'(chan));
    check("R1 chanSel", int'(chanSel), chan);
    timeConv(irqOn, "conv");
    checkResult(chan, val, (val > 1023) ? "R5 saturate" : "R4 value");
  endtask

  task automatic testReset();
    int v;
    repeat (3) @(negedge clk);
    check("R9 dac reset", int'(dacCode), 0);
    check("R9 irq reset", int'(irqReq), 0);
    regRead(2'd3, v); check("R9 status reset", v, 0);
    regRead(2'd1, v); check("R9 low reset", v, 0);
    regRead(2'd2, v); check("R9 high reset", v, 0);
    rstN = 1'b1;
  endtask

  task automatic testHold();
    int v;
    logic [9:0] dacSnap;
    dacSnap = dacCode;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      regRead(2'd2, v);
    end
    regWrite(2'd1, 8'hFF);
    regWrite(2'd2, 8'hFF);
    regRead(2'd3, v);
    check("R8 ready kept after reads", v & 1, 1);
    check("R8 dac held", int'(dacCode), int'(dacSnap));
    checkResult(6, 682, "R8 result unchanged");
  endtask

  task automatic testAbort();
    int v;
    regWrite(2'd3, 8'h02);
    analogVal = 100;
    regWrite(2'd0, 8'h02);
    repeat (50) @(negedge clk);
    analogVal = 777;
    regWrite(2'd0, 8'h09);
    check("R7 new channel", int'(chanSel), 9);
    timeConv(1'b1, "R7 restart");
    checkResult(9, 777, "R7 restart");
  endtask

  initial begin
    #(20 * 200000);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    runConv(5, 300, 1'b1);
    runConv(0, 0, 1'b0);
    runConv(15, 1023, 1'b1);
    runConv(7, 5000, 1'b0);
    runConv(3, 341, 1'b1);
    runConv(9, 1, 1'b0);
    runConv(6, 682, 1'b1);
    testHold();
    testAbort();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule